// File: doc/BRIEF.md
# Floating-Point Sign-Injection Unit with Boxed Singles

The unit takes two 64-bit floating-point register values and builds a result by combining the magnitude bits of the first operand with a sign bit that comes from the second operand. Three sign rules are offered: take the sign of operand 2, take its inverse, or take the XOR of both operand signs. Each rule works in either double or single precision. In single precision the 32-bit values are carried inside 64-bit registers. A value is valid only when its upper half is all ones. Any other single-precision operand is read as the positive canonical quiet NaN. Single-precision results are written back boxed in the same way.

A fourth operation moves a value to the integer side. A single is returned as its low 32 bits sign-extended to 64 bits. A double is returned unchanged. The operation and precision selects are captured together with the operands on a valid strobe. The result appears registered one cycle later and holds until the next strobe.

Top module: `fp_sgnj_unit`

## Requirements
- R1: In double precision with op_i = 0 (copy), result bit 63 equals operand 2 bit 63.
- R2: With op_i = 1 (negate), the result sign equals the inverse of operand 2's sign. The sign is bit 63 in double precision and bit 31 in single precision.
- R3: With op_i = 2 (xor), the result sign equals the XOR of the two operand signs.
- R4: In double precision with op_i in 0..2, result bits 62:0 equal operand 1 bits 62:0.
- R5: In single precision, operand 1 whose bits 63:32 are not all ones is replaced by 0x7fc00000 before sign injection. For example, operand 1 = 0x7ffffffe12345678 copied with operand 2 = 0 gives 0xffffffff7fc00000.
- R6: In single precision, operand 2 whose bits 63:32 are not all ones contributes sign 0. For example, operand 2 = 0x7fffffff80000000 gives sign 0.
- R7: Single-precision results with op_i in 0..2 have bits 63:32 = 0xffffffff. Bits 30:0 are taken from the operand-1 value, which is the canonical NaN when operand 1 is badly boxed.
- R8: With op_i = 3 (move), a single returns operand 1 bits 31:0 sign-extended to 64 bits, and a double returns operand 1 unchanged.
- R9: result_o and valid_o update one clock after a cycle with valid_i high. When valid_i is low, result_o holds its value and valid_o is 0.
- R10: After reset, valid_o is 0 and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input strobe |
| op_i | input | 2 | 0 copy, 1 negate, 2 xor, 3 move to integer |
| dbl_i | input | 1 | 1 double precision, 0 single precision |
| op1_i | input | 64 | Operand 1 (magnitude source) |
| op2_i | input | 64 | Operand 2 (sign source) |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 64 | Registered result |

## Verification
The assertions assume that op_i, dbl_i and both operands are stable and known in any cycle where valid_i is high. They also assume that reset is held for at least one clock edge. The stimulus changes inputs only on the falling clock edge, one full half-cycle before capture. The sweep covers all four operations, both precisions, both signs of each operand, and well-boxed, badly boxed and nearly boxed upper halves. The hold checks alter the operands while valid_i is low, so any leak of unstrobed inputs into the result shows up.

// File: rtl/fp_sgnj_pkg.sv
package fp_sgnj_pkg;
  localparam int unsigned FLEN = 64;
  localparam int unsigned SLEN = 32;
  localparam logic [SLEN-1:0] CANON_NAN_S = {1'b0, {(8+1){1'b1}}, {(SLEN-10){1'b0}}};

  typedef enum logic [1:0] {
    SGNJ_COPY = 2'd0,
    SGNJ_NEG  = 2'd1,
    SGNJ_XOR  = 2'd2,
    SGNJ_MOVE = 2'd3
  } sgnj_op_e;
endpackage

// File: rtl/fp_unbox.sv
module fp_unbox
  import fp_sgnj_pkg::*;
#(
  parameter int unsigned WIDE   = FLEN,
  parameter int unsigned NARROW = SLEN
) (
  input  logic [WIDE-1:0]   reg_i,
  output logic [NARROW-1:0] val_o
);
  localparam int unsigned PAD = WIDE - NARROW;
  logic boxed;
  assign boxed = &reg_i[WIDE-1:NARROW];
  assign val_o = boxed ? reg_i[NARROW-1:0] : CANON_NAN_S[NARROW-1:0];

  always_comb begin
    assert (PAD > 0);
  end
endmodule

// File: rtl/fp_sign_mix.sv
module fp_sign_mix
  import fp_sgnj_pkg::*;
#(
  parameter int unsigned W = FLEN
) (
  input  sgnj_op_e     op_i,
  input  logic         s1_i,
  input  logic         s2_i,
  input  logic [W-2:0] mag_i,
  output logic [W-1:0] res_o
);
  logic sign;
  always_comb begin
    unique case (op_i)
      SGNJ_NEG: sign = ~s2_i;
      SGNJ_XOR: sign = s1_i ^ s2_i;
      default:  sign = s2_i;
    endcase
  end
  assign res_o = {sign, mag_i};
endmodule

// File: rtl/fp_sgnj_unit.sv
module fp_sgnj_unit
  import fp_sgnj_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [1:0]  op_i,
  input  logic        dbl_i,
  input  logic [63:0] op1_i,
  input  logic [63:0] op2_i,
  output logic        valid_o,
  output logic [63:0] result_o
);
  localparam int unsigned PAD = FLEN - SLEN;

  sgnj_op_e op;
  assign op = sgnj_op_e'(op_i);

  logic [SLEN-1:0] s_a, s_b, s_res;
  logic [FLEN-1:0] d_res, comb_res;

  fp_unbox #(.WIDE(FLEN), .NARROW(SLEN)) i_unbox_a (.reg_i(op1_i), .val_o(s_a));
  fp_unbox #(.WIDE(FLEN), .NARROW(SLEN)) i_unbox_b (.reg_i(op2_i), .val_o(s_b));

  fp_sign_mix #(.W(SLEN)) i_mix_s (
    .op_i(op), .s1_i(s_a[SLEN-1]), .s2_i(s_b[SLEN-1]),
    .mag_i(s_a[SLEN-2:0]), .res_o(s_res)
  );
  fp_sign_mix #(.W(FLEN)) i_mix_d (
    .op_i(op), .s1_i(op1_i[FLEN-1]), .s2_i(op2_i[FLEN-1]),
    .mag_i(op1_i[FLEN-2:0]), .res_o(d_res)
  );

  logic unused_bits;
  assign unused_bits = ^s_b[SLEN-2:0];

  always_comb begin
    if (op == SGNJ_MOVE)
      comb_res = dbl_i ? op1_i : {{PAD{op1_i[SLEN-1]}}, op1_i[SLEN-1:0]};
    else
      comb_res = dbl_i ? d_res : {{PAD{1'b1}}, s_res};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= comb_res;
    end
  end

  assert_neg_sign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dbl_i && op_i == 2'd1 |=> result_o[63] != $past(op2_i[63]));
  assert_dbl_low_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dbl_i && op_i != 2'd3 |=> result_o[62:0] == $past(op1_i[62:0]));
  assert_single_boxed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !dbl_i && op_i != 2'd3 |=> &result_o[63:32]);
  assert_move_dbl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dbl_i && op_i == 2'd3 |=> result_o == $past(op1_i));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && !valid_o);
  assert_valid_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
endmodule

// File: tb/test_fp_sgnj_unit.sv
module test_fp_sgnj_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [1:0] op = '0;
  logic dbl = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic valid_o;
  logic [63:0] res_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_sgnj_unit i_fp_sgnj_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .dbl_i(dbl),
    .op1_i(a), .op2_i(b), .valid_o(valid_o), .result_o(res_o)
  );

  function automatic logic [63:0] model(logic [1:0] o, logic d, logic [63:0] x, logic [63:0] y);
    logic [31:0] xv, yv;
    logic s1, s2, ns;
    if (o == 2'd3) return d ? x : {{32{x[31]}}, x[31:0]};
    xv = (x[63:32] == 32'hffffffff) ? x[31:0] : 32'h7fc00000;
    yv = (y[63:32] == 32'hffffffff) ? y[31:0] : 32'h7fc00000;
    s1 = d ? x[63] : xv[31];
    s2 = d ? y[63] : yv[31];
    ns = (o == 2'd0) ? s2 : (o == 2'd1) ? ~s2 : s1 ^ s2;
    return d ? {ns, x[62:0]} : {32'hffffffff, ns, xv[30:0]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic [1:0] o, logic d, logic [63:0] x, logic [63:0] y);
    logic [63:0] e;
    e = model(o, d, x, y);
    @(negedge clk);
    valid = 1'b1; op = o; dbl = d; a = x; b = y;
    @(negedge clk);
    valid = 1'b0;
    chk({tag, " result"}, res_o, e);
    chk("R9 valid_o high", {63'd0, valid_o}, 64'd1);
    a = ~x; b = ~y; op = ~o; dbl = ~d;
    @(negedge clk);
    chk("R9 hold", res_o, e);
    chk("R9 valid_o low", {63'd0, valid_o}, 64'd0);
  endtask

  initial begin
    logic [31:0] his [3];
    logic [30:0] pays [3];
    string tag;
    his[0] = 32'hffffffff; his[1] = 32'h7fffffff; his[2] = 32'hfffffffe;
    pays[0] = 31'h12345678; pays[1] = 31'h7fc00000; pays[2] = 31'h11111111;

    #2;
    chk("R10 valid_o reset", {63'd0, valid_o}, 64'd0);
    chk("R10 result reset", res_o, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    run("R5", 2'd0, 1'b0, 64'h7ffffffe12345678, 64'h0);
    run("R6", 2'd0, 1'b0, 64'hffffffff12345678, 64'h7fffffff80000000);
    run("R7", 2'd0, 1'b0, 64'hffffffff12345678, 64'hffffffff80000000);
    run("R4", 2'd0, 1'b1, 64'hffffffff11111111, 64'h7fffffff11111111);
    run("R8", 2'd3, 1'b0, 64'h00000000deadbeef, 64'h0);

    for (int o = 0; o < 4; o++)
      for (int d = 0; d < 2; d++)
        for (int ha = 0; ha < 3; ha++)
          for (int hb = 0; hb < 3; hb++)
            for (int sa = 0; sa < 2; sa++)
              for (int sb = 0; sb < 2; sb++)
                for (int p = 0; p < 3; p++) begin
                  logic [63:0] x, y;
                  x = {his[ha], sa[0], pays[p]};
                  y = {his[hb], sb[0], pays[(p + 1) % 3]};
                  if (d == 1) begin x[63] = sa[0]; y[63] = sb[0]; end
                  if (o == 3) tag = "R8";
                  else if (d == 1) tag = (o == 0) ? "R1" : (o == 1) ? "R2" : "R3";
                  else if (ha != 0) tag = "R5";
                  else if (hb != 0) tag = "R6";
                  else tag = "R7";
                  run(tag, o[1:0], d[0], x, y);
                end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule